// File: doc/BRIEF.md
# Link Mode Priority Resolver

This block chooses the operating mode of an Ethernet twisted-pair link once ability exchange with the far end has finished. It takes two 16-bit words: the local advertisement and the partner's ability word. It intersects the five ability bits of the two words and picks the single best mode both ends share, using a fixed priority. The result is reported as one-hot mode flags, a 100 Mb/s flag and a full-duplex flag.

A result counts only when both words carry the CSMA/CD selector code. The decision is captured in registers on a one-cycle completion strobe and is held until the next strobe, so the link layer above sees a stable answer. The partner's remote-fault indication is captured at the same moment and reported on its own output.

Control is a three-state machine. EMPTY is the state after reset, when no decision has been taken. LINKED means the last strobe found a common mode with matching selectors. REJECT means the last strobe found no common mode or a selector mismatch. Every state moves on a strobe: it goes to LINKED when the resolution succeeds (transition RESOLVE_OK) and to REJECT otherwise (transition RESOLVE_FAIL). Without a strobe every state stays where it is. Synchronous reset returns the machine to EMPTY from any state.

Top module: `link_mode_resolver`

## Requirements
- R1: The ability bits sit at the same positions in both words: bit 9 is 100Base-T4, bit 8 is 100Base-TX full duplex, bit 7 is 100Base-TX, bit 6 is 10Base-T full duplex and bit 5 is 10Base-T. The common set is the bitwise AND of bits 9:5 of the two words.
- R2: Of the common modes, the chosen one is the highest in this order: 100Base-TX full duplex, 100Base-T4, 100Base-TX half duplex, 10Base-T full duplex, 10Base-T half duplex.
- R3: When either word's bits 4:0 differ from 5'b00001, valid is low and mode_oh is zero after the strobe.
- R4: Bits 15:10 of both words have no effect on mode_oh, valid, speed_100 or full_duplex.
- R5: When the common set is empty, valid is low and mode_oh, speed_100 and full_duplex are zero after the strobe.
- R6: speed_100 is high exactly when the chosen mode is one of the three 100 Mb/s modes.
- R7: full_duplex is high exactly when the chosen mode is one of the two full-duplex modes.
- R8: Outputs change only in the cycle after done is high. Input changes without done leave them unchanged.
- R9: Synchronous reset clears valid, mode_oh, speed_100, full_duplex and remote_fault.
- R10: remote_fault takes bit 13 of the partner word at the strobe and has no effect on the mode choice.
- R11: mode_oh is one-hot when valid and zero otherwise. Bit 4 means 100Base-TX full duplex, bit 3 means 100Base-T4, bit 2 means 100Base-TX half duplex, bit 1 means 10Base-T full duplex and bit 0 means 10Base-T half duplex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| done | input | 1 | One-cycle strobe that marks the end of negotiation |
| local_word | input | 16 | Local advertisement word |
| partner_word | input | 16 | Partner ability word |
| mode_oh | output | 5 | One-hot chosen mode (R11 encoding) |
| valid | output | 1 | A common mode exists and both selectors are CSMA/CD |
| speed_100 | output | 1 | Chosen mode runs at 100 Mb/s |
| full_duplex | output | 1 | Chosen mode is full duplex |
| remote_fault | output | 1 | Partner remote-fault bit captured at the strobe |

## Verification
The bench builds the block with its default parameters: 16-bit words, a 5-bit selector compared against 5'b00001, and the ability field at bits 9:5. With these values all 32 ability patterns fall within reach, so the random words cover every common set and every winner of the priority. The selector is forced to the CSMA/CD code most of the time, so that results are mostly valid, while the upper bits are left fully random. Directed cases cover each single mode, the empty set, a mismatch on each side's selector, the hold behaviour without a strobe, and reset after a valid result.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
    localparam int N_MODES = 5;

    // Indices of the one-hot result, highest priority at the top.
    localparam int M_TXFD = 4;
    localparam int M_T4   = 3;
    localparam int M_TXHD = 2;
    localparam int M_10FD = 1;
    localparam int M_10HD = 0;

    // Positions inside the ability field (word bits 9:5 shifted down).
    localparam int A_T4   = 4;
    localparam int A_TXFD = 3;
    localparam int A_TX   = 2;
    localparam int A_10FD = 1;
    localparam int A_10   = 0;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_LINKED = 2'd1,
        ST_REJECT = 2'd2
    } res_state_t;
endpackage

// File: rtl/lmr_match.sv
module lmr_match #(
    parameter int ABIL_W   = 5,
    parameter int SEL_W    = 5,
    parameter logic [SEL_W-1:0] SEL_CODE = 5'b00001
) (
    input  logic [ABIL_W-1:0] loc_abil,
    input  logic [ABIL_W-1:0] par_abil,
    input  logic [SEL_W-1:0]  loc_sel,
    input  logic [SEL_W-1:0]  par_sel,
    output logic [ABIL_W-1:0] common,
    output logic              sel_ok
);
    always_comb begin
        common = loc_abil & par_abil;
        sel_ok = (loc_sel == SEL_CODE) && (par_sel == SEL_CODE);
    end
endmodule

// File: rtl/lmr_rank.sv
module lmr_rank
    import lmr_pkg::*;
(
    input  logic [N_MODES-1:0] common,
    output logic [N_MODES-1:0] grant,
    output logic               any
);
    logic [N_MODES-1:0] ranked;

    // Place the ability bits in priority order.
    always_comb begin
        ranked         = '0;
        ranked[M_TXFD] = common[A_TXFD];
        ranked[M_T4]   = common[A_T4];
        ranked[M_TXHD] = common[A_TX];
        ranked[M_10FD] = common[A_10FD];
        ranked[M_10HD] = common[A_10];
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_MODES; gi++) begin : g_pick
            if (gi == N_MODES - 1) begin : g_top
                assign grant[gi] = ranked[gi];
            end else begin : g_lower
                assign grant[gi] = ranked[gi] & ~(|ranked[N_MODES-1:gi+1]);
            end
        end
    endgenerate

    assign any = |ranked;
endmodule

// File: rtl/lmr_state.sv
module lmr_state
    import lmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               done,
    input  logic               res_ok,
    input  logic [N_MODES-1:0] grant,
    input  logic               rf_in,
    output logic [N_MODES-1:0] mode_oh,
    output logic               valid,
    output logic               speed_100,
    output logic               full_duplex,
    output logic               remote_fault
);
    res_state_t         state_q, state_d;
    logic [N_MODES-1:0] mode_q;
    logic               rf_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY, ST_LINKED, ST_REJECT: begin
                if (done) state_d = res_ok ? ST_LINKED : ST_REJECT;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
            mode_q  <= '0;
            rf_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (done) begin
                mode_q <= res_ok ? grant : '0;
                rf_q   <= rf_in;
            end
        end
    end

    always_comb begin
        mode_oh      = '0;
        valid        = 1'b0;
        unique case (state_q)
            ST_LINKED: begin
                mode_oh = mode_q;
                valid   = 1'b1;
            end
            ST_EMPTY, ST_REJECT: begin
                mode_oh = '0;
                valid   = 1'b0;
            end
            default: begin
                mode_oh = '0;
                valid   = 1'b0;
            end
        endcase
        speed_100    = mode_oh[M_TXFD] | mode_oh[M_T4] | mode_oh[M_TXHD];
        full_duplex  = mode_oh[M_TXFD] | mode_oh[M_10FD];
        remote_fault = rf_q;
    end
endmodule

// File: rtl/link_mode_resolver.sv
module link_mode_resolver
    import lmr_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int SEL_W    = 5,
    parameter int ABIL_LSB = 5,
    parameter int RF_BIT   = 13,
    parameter logic [SEL_W-1:0] SEL_CODE = 5'b00001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [WORD_W-1:0] local_word,
    input  logic [WORD_W-1:0] partner_word,
    output logic [N_MODES-1:0] mode_oh,
    output logic              valid,
    output logic              speed_100,
    output logic              full_duplex,
    output logic              remote_fault
);
    localparam int ABIL_HI = ABIL_LSB + N_MODES - 1;

    logic [N_MODES-1:0] common;
    logic [N_MODES-1:0] grant;
    logic               sel_ok;
    logic               any;
    logic               unused_bits;

    assign unused_bits = ^{local_word[WORD_W-1:ABIL_HI+1], partner_word[WORD_W-1:ABIL_HI+1]};

    lmr_match #(
        .ABIL_W   (N_MODES),
        .SEL_W    (SEL_W),
        .SEL_CODE (SEL_CODE)
    ) u_match (
        .loc_abil (local_word[ABIL_HI:ABIL_LSB]),
        .par_abil (partner_word[ABIL_HI:ABIL_LSB]),
        .loc_sel  (local_word[SEL_W-1:0]),
        .par_sel  (partner_word[SEL_W-1:0]),
        .common   (common),
        .sel_ok   (sel_ok)
    );

    lmr_rank u_rank (
        .common (common),
        .grant  (grant),
        .any    (any)
    );

    lmr_state u_state (
        .clk          (clk),
        .rst          (rst),
        .done         (done),
        .res_ok       (sel_ok & any),
        .grant        (grant),
        .rf_in        (partner_word[RF_BIT]),
        .mode_oh      (mode_oh),
        .valid        (valid),
        .speed_100    (speed_100),
        .full_duplex  (full_duplex),
        .remote_fault (remote_fault)
    );
endmodule

// File: rtl/lmr_checker.sv
module lmr_checker (
    input logic        clk,
    input logic        rst,
    input logic        done,
    input logic [15:0] partner_word,
    input logic [4:0]  mode_oh,
    input logic        valid,
    input logic        speed_100,
    input logic        full_duplex,
    input logic        remote_fault
);
    p_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        valid |-> ($countones(mode_oh) == 1));

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (mode_oh == 5'd0 && !speed_100 && !full_duplex));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |=> ($stable(mode_oh) && $stable(valid) && $stable(remote_fault)));

    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!valid && mode_oh == 5'd0 && !remote_fault));

    p_rf_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (remote_fault == $past(partner_word[13])));

    p_speed_r6: assert property (@(posedge clk) disable iff (rst)
        speed_100 |-> (mode_oh[4] || mode_oh[3] || mode_oh[2]));
endmodule

bind link_mode_resolver lmr_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .done         (done),
    .partner_word (partner_word),
    .mode_oh      (mode_oh),
    .valid        (valid),
    .speed_100    (speed_100),
    .full_duplex  (full_duplex),
    .remote_fault (remote_fault)
);

// File: tb/link_mode_resolver_test.sv
module link_mode_resolver_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        done = 1'b0;
    logic [15:0] local_word = '0;
    logic [15:0] partner_word = '0;
    logic [4:0]  mode_oh;
    logic        valid, speed_100, full_duplex, remote_fault;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;  // 50 MHz

    link_mode_resolver uut (
        .clk(clk), .rst(rst), .done(done),
        .local_word(local_word), .partner_word(partner_word),
        .mode_oh(mode_oh), .valid(valid), .speed_100(speed_100),
        .full_duplex(full_duplex), .remote_fault(remote_fault)
    );

    // Expected outputs packed as {valid, mode[4:0], speed, fdx, rf}
    function automatic logic [8:0] expect_of(input logic [15:0] l, input logic [15:0] p);
        logic [4:0] c, m;
        c = l[9:5] & p[9:5];
        m = 5'd0;
        if (l[4:0] == 5'b00001 && p[4:0] == 5'b00001) begin
            if      (c[3]) m = 5'b10000;
            else if (c[4]) m = 5'b01000;
            else if (c[2]) m = 5'b00100;
            else if (c[1]) m = 5'b00010;
            else if (c[0]) m = 5'b00001;
        end
        return {(m != 0), m, (m[4] | m[3] | m[2]), (m[4] | m[1]), p[13]};
    endfunction

    function automatic logic [8:0] actual();
        return {valid, mode_oh, speed_100, full_duplex, remote_fault};
    endfunction

    task automatic check(input string req, input logic [8:0] exp);
        n_checks++;
        if (actual() !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, actual(), exp);
        end
    endtask

    // Apply words with a strobe, check after the loading edge.
    task automatic apply(input string req, input logic [15:0] l, input logic [15:0] p);
        @(negedge clk);
        local_word = l; partner_word = p; done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        check(req, expect_of(l, p));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R9 reset", 9'd0);
        rst = 1'b0;

        // R1/R11 single-mode cases
        apply("R1 t4",    16'h0201, 16'h0201);
        apply("R1 txfd",  16'h0101, 16'h0101);
        apply("R1 tx",    16'h0081, 16'h0081);
        apply("R1 10fd",  16'h0041, 16'h0041);
        apply("R11 10hd", 16'h0021, 16'h0021);
        // R2 priority
        apply("R2 txfd over t4", 16'h03E1, 16'h03E1);
        apply("R2 t4 over tx",   16'h02E1, 16'h02A1);
        apply("R2 10fd over 10", 16'h0061, 16'h0061);
        // R5 empty common set
        apply("R5 empty", 16'h0201, 16'h0101);
        // R3 selector mismatch on each side
        apply("R3 local sel",   16'h03E2, 16'h03E1);
        apply("R3 partner sel", 16'h03E1, 16'h03E0);
        // R4 upper bits ignored, R10 rf
        apply("R4 upper bits", 16'hFC81, 16'h1C81);
        apply("R10 rf set",    16'h0021, 16'hE021);
        apply("R6 R7 tx fd",   16'h0101, 16'hE1E1);

        // R8 hold without strobe
        held = actual();
        @(negedge clk);
        local_word = 16'h0021; partner_word = 16'h0021;
        @(negedge clk);
        @(negedge clk);
        check("R8 hold", held);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] l, p;
            l = 16'($urandom);
            p = 16'($urandom);
            if (($urandom % 8) != 0) begin
                l[4:0] = 5'b00001;
                p[4:0] = 5'b00001;
            end
            apply("R2 random", l, p);
        end

        // R9 reset after a valid result
        apply("R9 pre", 16'h0101, 16'h2101);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R9 reset clears", 9'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule